// File: doc/BRIEF.md
# Thermal Throttle Controller

This block decides when core clock modulation is applied for thermal protection. It watches an over-temperature flag from an external comparator, a thermal-monitor enable bit and an active-low force request that arrives asynchronously from the platform. From these it drives a throttle-active flag and a hot indication. It also drives a clock-enable pattern that a clock gate uses to slow the core while throttling.

Throttling that starts because of temperature ends only when two things are true: the comparator has gone quiet, and a hysteresis down-counter has run out. The counter is reloaded every cycle the comparator reports over-temperature. A platform force request holds throttling on for as long as it stays asserted. It first passes through a two-stage synchronizer. The modulator runs a fixed-length period and enables the clock for a programmable number of cycles at the start of each period.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: After reset, `tcc_active` and `thermal_hot` are 0 and `clk_enable` is 1.
- R2: When `over_temp` is 1 and `monitor_en` is 1 at a rising clock edge, `tcc_active` and `thermal_hot` are 1 from that edge on.
- R3: Temperature-caused throttling falls at the (HYST_CYCLES+1)-th consecutive edge at which `over_temp` is sampled 0. Any edge that samples `over_temp` 1 restarts this count.
- R4: When `force_n` is held 0 and `monitor_en` is 1, `tcc_active` rises after the second rising edge that samples the low level, because of the two-stage synchronizer. `thermal_hot` does not rise because of this request.
- R5: A force request keeps `tcc_active` at 1 for as long as it is held. Once `force_n` returns to 1, and no thermal cause is present, `tcc_active` falls after the second edge that samples the high level.
- R6: While `monitor_en` is 0, `tcc_active` and `thermal_hot` are 0 at once, whatever `over_temp` and `force_n` are. The thermal state is cleared at the next edge, so enabling the monitor again does not bring back earlier throttling.
- R7: While `tcc_active` is 1, `clk_enable` is 1 exactly when the current position in the period is below `duty_on`. The position is n mod PERIOD, where n counts the active cycles from 0. A `duty_on` of PERIOD or more keeps the clock enabled in every cycle.
- R8: While `tcc_active` is 0, `clk_enable` is 1. The next throttle episode starts again at position 0 of the period.
- R9: `thermal_hot` is 1 only when the throttling has a thermal cause. A force request on its own never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| over_temp | input | 1 | Comparator flag, synchronous, 1 = at or above the limit |
| monitor_en | input | 1 | Thermal monitor enable |
| force_n | input | 1 | Asynchronous force request, active low |
| duty_on | input | $clog2(PERIOD+1) | Number of enabled cycles per modulation period |
| tcc_active | output | 1 | Throttling is in effect |
| thermal_hot | output | 1 | Throttling has a thermal cause |
| clk_enable | output | 1 | Enable for the core clock gate |

## Verification
Inputs change just after a rising edge. Outputs are compared one time unit after the next edge, against a cycle-level model built from the requirements. The model applies the delays that the requirements state:
- The thermal state changes at the same edge that samples `over_temp`.
- A force request takes effect two edges after it changes.
- `monitor_en` acts at once through the output gating.
- The modulator position advances by one per active cycle.

The sweeps cover every `duty_on` from 0 to PERIOD under a force request and under thermal throttling. Directed cases count the exact edge at which hysteresis ends, and show that a single high sample in the middle of a countdown restarts it.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef struct packed {
    logic thermal;
    logic forced;
  } tcc_cause_t;
endpackage

// File: rtl/tcc_sync.sv
module tcc_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= RESET_VAL;
    else        chain_q[0] <= d_async;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[s] <= RESET_VAL;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tcc_hyst_timer.sv
module tcc_hyst_timer #(
  parameter int HYST_CYCLES = 6,
  localparam int CW = $clog2(HYST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic over_temp,
  output logic therm_active
);
  localparam logic [CW-1:0] RELOAD = CW'(HYST_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (over_temp) begin
      active_q <= 1'b1;
      cnt_q    <= RELOAD;
    end else if (active_q) begin
      if (cnt_q != '0) cnt_q    <= cnt_q - 1'b1;
      else             active_q <= 1'b0;
    end
  end

  assign therm_active = active_q;

  // R2: a sample at or above the limit arms the state and the full timer
  assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && over_temp) |=> (active_q && cnt_q == RELOAD));
  // R3: while time remains, the state is held
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && active_q && cnt_q != '0) |=> active_q);
  // R6: disabling clears the thermal state
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!active_q && cnt_q == '0));
endmodule

// File: rtl/tcc_duty_mod.sv
module tcc_duty_mod #(
  parameter int PERIOD = 8,
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1,
  localparam int DW = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [DW-1:0] duty_on,
  output logic          clk_en
);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !active)  phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                    phase_q <= phase_q + 1'b1;
  end

  assign clk_en = !active || ({{(DW-PW+1){1'b0}}, phase_q} < {1'b0, duty_on});

  // R8: an idle cycle leaves the period at its start
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> phase_q == '0);
  // R7: the position stays inside the period
  assert_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> (phase_q <= LAST));
  // R7: the position steps by one while active
  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && phase_q != LAST) |=> phase_q == $past(phase_q) + 1'b1);
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl #(
  parameter int HYST_CYCLES = 6,
  parameter int PERIOD = 8,
  localparam int DW = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          over_temp,
  input  logic          monitor_en,
  input  logic          force_n,
  input  logic [DW-1:0] duty_on,
  output logic          tcc_active,
  output logic          thermal_hot,
  output logic          clk_enable
);
  import tcc_pkg::*;

  logic       force_n_sync;
  logic       therm_state;
  tcc_cause_t cause;

  tcc_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(force_n), .q_sync(force_n_sync)
  );

  tcc_hyst_timer #(.HYST_CYCLES(HYST_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(monitor_en),
    .over_temp(over_temp), .therm_active(therm_state)
  );

  always_comb begin
    cause.thermal = monitor_en && therm_state;
    cause.forced  = monitor_en && !force_n_sync;
  end

  assign tcc_active  = cause.thermal || cause.forced;
  assign thermal_hot = cause.thermal;

  tcc_duty_mod #(.PERIOD(PERIOD)) u_mod (
    .clk(clk), .rst_n(rst_n), .active(tcc_active),
    .duty_on(duty_on), .clk_en(clk_enable)
  );

  // R9: the hot flag never appears without throttling
  assert_hot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_hot |-> tcc_active);
  // R6: nothing is active while the monitor is off
  assert_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !monitor_en |-> (!tcc_active && !thermal_hot));
  // R8: the clock runs freely when idle
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tcc_active |-> clk_enable);
endmodule

// File: tb/test_thermal_throttle_ctrl.sv
module test_thermal_throttle_ctrl;
  localparam int H = 5;
  localparam int PER = 8;
  localparam int DW = $clog2(PER + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic over_temp = 1'b0, monitor_en = 1'b0, force_n = 1'b1;
  logic [DW-1:0] duty_on = '0;
  logic tcc_active, thermal_hot, clk_enable;

  int checks = 0, errors = 0;
  string req = "R1";
  bit done = 0;

  // model state
  bit m_s1 = 1, m_s2 = 1, m_act = 0;
  int m_cnt = 0, m_ph = 0;

  always #2 clk = ~clk;

  thermal_throttle_ctrl #(.HYST_CYCLES(H), .PERIOD(PER)) i_thermal_throttle_ctrl (
    .clk(clk), .rst_n(rst_n), .over_temp(over_temp), .monitor_en(monitor_en),
    .force_n(force_n), .duty_on(duty_on), .tcc_active(tcc_active),
    .thermal_hot(thermal_hot), .clk_enable(clk_enable)
  );

  function automatic bit exp_tcc();
    return monitor_en && (m_act || !m_s2);
  endfunction

  task automatic chk(input string r, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", r, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    bit pre_tcc;
    @(posedge clk);
    pre_tcc = exp_tcc();
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_act = 0; m_cnt = 0; m_ph = 0;
    end else begin
      m_ph = pre_tcc ? ((m_ph == PER-1) ? 0 : m_ph + 1) : 0;
      m_s2 = m_s1; m_s1 = force_n;
      if (!monitor_en) begin m_act = 0; m_cnt = 0; end
      else if (over_temp) begin m_act = 1; m_cnt = H; end
      else if (m_act) begin
        if (m_cnt != 0) m_cnt--; else m_act = 0;
      end
    end
    #1;
    chk(req, "tcc_active", tcc_active, exp_tcc());
    chk(req, "thermal_hot", thermal_hot, monitor_en && m_act);
    chk(req, "clk_enable", clk_enable, !exp_tcc() || (m_ph < int'(duty_on)));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    // R1 reset state
    req = "R1";
    run(3);
    chk("R1", "tcc_active reset", tcc_active, 1'b0);
    chk("R1", "clk_enable reset", clk_enable, 1'b1);
    rst_n = 1'b1; monitor_en = 1'b1; duty_on = 4;
    run(2);

    // R2 and R3: one-cycle over-temp, count edges to deassertion
    req = "R3";
    over_temp = 1'b1;
    cyc();
    chk("R2", "tcc after trip edge", tcc_active, 1'b1);
    chk("R2", "hot after trip edge", thermal_hot, 1'b1);
    over_temp = 1'b0;
    n = 0;
    while (tcc_active && n < 50) begin cyc(); n++; end
    checks++;
    if (n != H + 1) begin
      errors++;
      $display("FAIL R3 edges to release actual=%0d expected=%0d", n, H + 1);
    end

    // R3 restart by a mid-countdown high sample
    over_temp = 1'b1; cyc(); over_temp = 1'b0; run(3);
    over_temp = 1'b1; cyc(); over_temp = 1'b0;
    n = 0;
    while (tcc_active && n < 50) begin cyc(); n++; end
    checks++;
    if (n != H + 1) begin
      errors++;
      $display("FAIL R3 restart edges actual=%0d expected=%0d", n, H + 1);
    end

    // R4, R5, R9 and R7 sweep under force
    for (int d = 0; d <= PER; d++) begin
      req = "R7";
      duty_on = DW'(d);
      force_n = 1'b0;
      cyc();
      chk("R4", "no tcc one edge after force", tcc_active, 1'b0);
      cyc();
      chk("R4", "tcc two edges after force", tcc_active, 1'b1);
      chk("R9", "hot under force only", thermal_hot, 1'b0);
      run(2 * PER + 3);
      chk("R5", "held while forced", tcc_active, 1'b1);
      force_n = 1'b1;
      req = "R5";
      cyc();
      chk("R5", "still active one edge after release", tcc_active, 1'b1);
      cyc();
      chk("R5", "released two edges later", tcc_active, 1'b0);
      chk("R8", "clock free when idle", clk_enable, 1'b1);
      run(2);
    end

    // R7 sweep under thermal throttling
    for (int d = 0; d <= PER; d++) begin
      req = "R7";
      duty_on = DW'(d);
      over_temp = 1'b1;
      run(PER + 3);
      over_temp = 1'b0;
      req = "R8";
      run(H + 3);
      chk("R8", "idle after thermal", clk_enable, 1'b1);
    end

    // R6: monitor off ignores both causes, clears state
    req = "R6";
    monitor_en = 1'b0; over_temp = 1'b1; force_n = 1'b0;
    run(4);
    chk("R6", "tcc off while disabled", tcc_active, 1'b0);
    chk("R6", "hot off while disabled", thermal_hot, 1'b0);
    over_temp = 1'b0; force_n = 1'b1;
    run(3);
    monitor_en = 1'b1;
    #1;
    chk("R6", "no revived state", tcc_active, 1'b0);
    over_temp = 1'b1; run(2);
    monitor_en = 1'b0;
    #1;
    chk("R6", "immediate drop on disable", tcc_active, 1'b0);
    over_temp = 1'b0;
    run(2);
    monitor_en = 1'b1;
    run(3);
    chk("R6", "cleared state after re-enable", tcc_active, 1'b0);

    // R9: thermal and force together, then force only
    req = "R9";
    force_n = 1'b0; over_temp = 1'b1;
    run(4);
    chk("R9", "hot with thermal cause", thermal_hot, 1'b1);
    over_temp = 1'b0;
    run(H + 3);
    chk("R9", "force keeps tcc", tcc_active, 1'b1);
    chk("R9", "hot drops with thermal", thermal_hot, 1'b0);
    force_n = 1'b1;
    run(4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule